// File: doc/BRIEF.md
# Double-Buffered Eight-Channel DAC Code Register Bank

This block is the digital front end for an eight-channel, 13-bit converter with a parallel write port. A host presents a code on a 13-bit data bus and a channel number on a 3-bit address. It then pulls the active-low select and write strobes low to fill that channel's input register. A single active-low load strobe copies every input register into its channel's DAC register at the same time, so all eight outputs can change together. The DAC registers drive the eight code outputs to the analog side. An active-low clear raises a per-channel flag that tells the analog side to park its output at the sense-ground level. The clear touches no stored code.

All strobes are level sensitive. Each register is transparent in every clock cycle in which its enable condition holds. When select, write and load are all low at once, bus changes flow straight through to the addressed channel's code output. The strobes pass through a two-flop synchronizer. The data and address are delayed by the same number of stages, so that all of them stay aligned. The interface is a plain strobe port with no valid/ready handshake and no back-pressure: the host owns the timing, and the block accepts every cycle.

Top module: `octal_dac_regbank`

## Requirements
- R1: The block holds eight channels. Each has a 13-bit input register and a separate 13-bit DAC register. Channel n's DAC register drives `dac_code[13n+12:13n]`.
- R2: Address value n (000 to 111) selects channel n, from channel 0 at 000 to channel 7 at 111. A write changes only the addressed channel and leaves the other seven unchanged.
- R3: The addressed input register follows `bus_data` in every cycle in which `sel_n` and `wr_n` are both low. It holds its value whenever either of them is high.
- R4: While `load_n` is low, all eight DAC registers follow their input registers. While `load_n` is high, they hold.
- R5: With `sel_n`, `wr_n` and `load_n` all low, a change on `bus_data` reaches the addressed channel's code output with the same latency as any other input change.
- R6: While `clr_n` is low, every bit of `gnd_force` is 1. The input and DAC registers, and therefore `dac_code`, stay unchanged. After `clr_n` returns high, `gnd_force` returns to 0 and the earlier outputs stand.
- R7: A change on any input pin first shows at the outputs after the third rising clock edge: two synchronizer stages plus one register stage.
- R8: A synchronous reset (`rst_n` low at a rising edge) sets all sixteen registers to 4096 (mid-scale) and clears `gnd_force`.
- R9: Codes are offset binary and pass through without change. 0 is the most negative output, 4096 is mid-scale and 8191 is the most positive. Both extremes survive the two register stages intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_data | input | 13 | Parallel code bus, offset binary |
| bus_addr | input | 3 | Channel select for writes |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| load_n | input | 1 | Global load into all DAC registers, active low |
| clr_n | input | 1 | Clear overlay, active low |
| dac_code | output | 104 | Eight 13-bit DAC register codes, channel 0 in the low bits |
| gnd_force | output | 8 | Per-channel request to drive the output to sense ground |

## Verification
The hardest state to reach from the ports is one where an input register holds a value that differs from its DAC register. The input register can only be seen through a later load. The bench writes new codes with load held high and confirms that the outputs do not move. It then pulses load alone and checks that the hidden values appear on all channels together. Flow-through is checked by holding all three strobes low while the bus changes, and by sampling exactly at the second and third edges. The check at the second edge must show no change yet; the check at the third edge must show the new code. Clear is verified by entering and leaving it around a set of distinct stored codes.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  // Active-low control strobes, kept together so they share one synchronizer path
  typedef struct packed {
    logic sel_n;
    logic wr_n;
    logic load_n;
    logic clr_n;
  } strobes_t;

  localparam strobes_t STROBES_IDLE = '{sel_n: 1'b1, wr_n: 1'b1, load_n: 1'b1, clr_n: 1'b1};
endpackage

// File: rtl/ctrl_sync.sv
module ctrl_sync
  import dac_bank_pkg::*;
#(
  parameter int CODE_W = 13,
  parameter int ADDR_W = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strb_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output strobes_t          strb_o,
  output logic [CODE_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_o
);
  strobes_t          strb_q [STAGES];
  logic [CODE_W-1:0] data_q [STAGES];
  logic [ADDR_W-1:0] addr_q [STAGES];

  // Strobes are synchronized; bus and address ride an equal-length delay line
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    strobes_t          strb_d;
    logic [CODE_W-1:0] data_d;
    logic [ADDR_W-1:0] addr_d;
    if (s == 0) begin : g_first
      assign strb_d = strb_i;
      assign data_d = data_i;
      assign addr_d = addr_i;
    end else begin : g_next
      assign strb_d = strb_q[s-1];
      assign data_d = data_q[s-1];
      assign addr_d = addr_q[s-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        strb_q[s] <= STROBES_IDLE;
        data_q[s] <= '0;
        addr_q[s] <= '0;
      end else begin
        strb_q[s] <= strb_d;
        data_q[s] <= data_d;
        addr_q[s] <= addr_d;
      end
    end
  end

  assign strb_o = strb_q[STAGES-1];
  assign data_o = data_q[STAGES-1];
  assign addr_o = addr_q[STAGES-1];

  // R7: a strobe change takes exactly STAGES edges (checked for the default depth of 2)
  p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES != 2) || ($past(rst_n) == 1'b0) || (strb_o == $past(strb_i, 2)));
endmodule

// File: rtl/chan_regs.sv
module chan_regs #(
  parameter int CODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              load_en,
  input  logic [CODE_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] in_q;
  logic [CODE_W-1:0] dac_q;
  logic [CODE_W-1:0] in_next;

  // The DAC stage sees the input stage's new value in the same cycle, which gives flow-through
  assign in_next = wr_en ? data : in_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= MID;
      dac_q <= MID;
    end else begin
      if (wr_en)   in_q  <= data;
      if (load_en) dac_q <= in_next;
    end
  end

  assign code = dac_q;

  // R3: without a write enable the input register keeps its contents
  p_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(in_q));
  // R4: the DAC register is frozen while load is inactive
  p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(dac_q));
  // R4: a load with no concurrent write copies the input register
  p_dac_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !wr_en) |=> (dac_q == in_q));
  // R8: reset lands both stages on mid-scale
  p_reset_mid_r8: assert property (@(posedge clk)
    !rst_n |=> (in_q == MID && dac_q == MID));
endmodule

// File: rtl/octal_dac_regbank.sv
module octal_dac_regbank
  import dac_bank_pkg::*;
#(
  parameter int CH_COUNT    = 8,
  parameter int CODE_W      = 13,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(CH_COUNT)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CODE_W-1:0]            bus_data,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         sel_n,
  input  logic                         wr_n,
  input  logic                         load_n,
  input  logic                         clr_n,
  output logic [CH_COUNT*CODE_W-1:0]   dac_code,
  output logic [CH_COUNT-1:0]          gnd_force
);
  strobes_t          strb_raw;
  strobes_t          strb_s;
  logic [CODE_W-1:0] data_s;
  logic [ADDR_W-1:0] addr_s;
  logic [CH_COUNT-1:0] wr_en;
  logic              load_en;
  logic              clr_act_q;

  assign strb_raw = '{sel_n: sel_n, wr_n: wr_n, load_n: load_n, clr_n: clr_n};

  ctrl_sync #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb_i (strb_raw),
    .data_i (bus_data),
    .addr_i (bus_addr),
    .strb_o (strb_s),
    .data_o (data_s),
    .addr_o (addr_s)
  );

  assign load_en = !strb_s.load_n;

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_chan
    assign wr_en[c] = !strb_s.sel_n && !strb_s.wr_n && (addr_s == ADDR_W'(c));
    chan_regs #(.CODE_W(CODE_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en[c]),
      .load_en (load_en),
      .data    (data_s),
      .code    (dac_code[c*CODE_W +: CODE_W])
    );
  end

  // The clear overlay is registered so that it shares the latency of the codes
  always_ff @(posedge clk) begin
    if (!rst_n) clr_act_q <= 1'b0;
    else        clr_act_q <= !strb_s.clr_n;
  end
  assign gnd_force = {CH_COUNT{clr_act_q}};

  // R2: at most one input register is opened per cycle
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  // R6: an active clear raises every flag on the next edge
  p_clear_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_s.clr_n |=> (gnd_force == {CH_COUNT{1'b1}}));
  // R6: the clear alone never moves a stored code
  p_clear_keeps_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_s.clr_n && !load_en) |=> $stable(dac_code));
  // R8: reset drops the clear flags
  p_reset_flag_r8: assert property (@(posedge clk)
    !rst_n |=> (gnd_force == '0));
endmodule

// File: tb/test_octal_dac_regbank.sv
module test_octal_dac_regbank;
  localparam int CH = 8;
  localparam int W  = 13;
  localparam logic [W-1:0] MID = 13'd4096;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] bus_data;
  logic [2:0]   bus_addr;
  logic sel_n, wr_n, load_n, clr_n;
  logic [CH*W-1:0] dac_code;
  logic [CH-1:0]   gnd_force;

  int vectors = 0;
  int miscompares = 0;
  logic [W-1:0] m_in  [CH];
  logic [W-1:0] m_dac [CH];

  always #2ns clk = ~clk;

  octal_dac_regbank i_octal_dac_regbank (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .sel_n(sel_n), .wr_n(wr_n), .load_n(load_n), .clr_n(clr_n),
    .dac_code(dac_code), .gnd_force(gnd_force)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] code_of(input int c);
    return dac_code[c*W +: W];
  endfunction

  task automatic chk_all(input string req);
    for (int c = 0; c < CH; c++) chk(req, code_of(c), m_dac[c]);
  endtask

  task automatic do_write(input int c, input logic [W-1:0] v);
    bus_addr = 3'(c); bus_data = v; sel_n = 0; wr_n = 0;
    tick(1);
    sel_n = 1; wr_n = 1;
    tick(1);
    m_in[c] = v;
  endtask

  task automatic do_load();
    load_n = 0; tick(1); load_n = 1; tick(1);
    for (int c = 0; c < CH; c++) m_dac[c] = m_in[c];
  endtask

  task automatic t_reset();
    rst_n = 0; tick(3); rst_n = 1; tick(3);
    for (int c = 0; c < CH; c++) begin m_in[c] = MID; m_dac[c] = MID; end
    chk_all("R8 reset mid-scale");
    chk("R8 reset flag", W'(gnd_force), '0);
  endtask

  task automatic t_write_each();
    for (int c = 0; c < CH; c++) do_write(c, W'(100 + 777 * c));
    do_load(); tick(3);
    chk_all("R1 R2 per-channel codes after load");
  endtask

  task automatic t_isolation();
    do_write(5, 13'd1234); do_load(); tick(3);
    chk_all("R2 single write leaves others untouched");
  endtask

  task automatic t_hold_no_load();
    do_write(2, 13'd3333); do_write(6, 13'd5555); tick(3);
    chk_all("R4 outputs hold while load high");
    do_load(); tick(3);
    chk_all("R4 load transfers hidden input values");
  endtask

  task automatic t_strobe_half();
    bus_addr = 3'd3; bus_data = 13'd77; sel_n = 0; wr_n = 1; tick(2);
    sel_n = 1; wr_n = 0; bus_data = 13'd88; tick(2);
    wr_n = 1; tick(1);
    do_load(); tick(3);
    chk_all("R3 one strobe high blocks the write");
  endtask

  task automatic t_flow_latency();
    bus_addr = 3'd4; bus_data = 13'd4001;
    sel_n = 0; wr_n = 0; load_n = 0;
    tick(2);
    chk("R7 no change after two edges", code_of(4), m_dac[4]);
    tick(1);
    chk("R5 R7 flow-through after third edge", code_of(4), 13'd4001);
    bus_data = 13'd17; tick(3);
    chk("R5 bus change follows live", code_of(4), 13'd17);
    sel_n = 1; wr_n = 1; load_n = 1; tick(3);
    m_in[4] = 13'd17; m_dac[4] = 13'd17;
    chk_all("R5 released flow keeps last value");
  endtask

  task automatic t_clear();
    clr_n = 0; tick(2);
    chk("R7 flag not yet set after two edges", W'(gnd_force), '0);
    tick(1);
    chk("R6 all flags raised", W'(gnd_force), W'(8'hFF));
    chk_all("R6 codes unchanged under clear");
    clr_n = 1; tick(3);
    chk("R6 flags released", W'(gnd_force), '0);
    do_load(); tick(3);
    chk_all("R6 stored registers survive clear");
  endtask

  task automatic t_extremes();
    do_write(0, 13'd0); do_write(7, 13'd8191); do_load(); tick(3);
    chk("R9 zero code", code_of(0), 13'd0);
    chk("R9 full code", code_of(7), 13'd8191);
  endtask

  initial begin
    rst_n = 0; bus_data = '0; bus_addr = '0;
    sel_n = 1; wr_n = 1; load_n = 1; clr_n = 1;
    tick(1);
    t_reset();
    t_write_each();
    t_isolation();
    t_hold_no_load();
    t_strobe_half();
    t_flow_latency();
    t_clear();
    t_extremes();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule